// File: doc/BRIEF.md
# Compensated Fixed-Width Booth Multiplier

This block multiplies two signed L-bit operands and returns only an L-bit result: the upper half of the 2L-bit product. It does not build the whole partial-product array. Radix-4 Booth recoding of the multiplier operand gives L/2 rows. Only the columns of weight 2^(L-w) and above are summed. Here w (0 to 4) is the number of columns below the output half that are kept for accuracy.

The carry that the dropped low columns would have sent upward is not computed. It is estimated from two things: the single column just below the kept region, and the per-row flags that mark a nonzero Booth digit. The estimate is added at the lowest kept column. A carry-save tree then reduces the rows to two, and a Brent-Kung prefix adder adds them. The w extra low columns are discarded at the end.

Raising w costs more columns of array and adder width and buys a smaller error against a properly rounded product. An optional output register gives a one-cycle pipeline with a valid flag.

Top module: `fwb_mult`

## Requirements
- R1: Row i (i = 0 .. L/2-1) uses Booth digit d_i = -2*b[2i+1] + b[2i] + b[2i-1], with b[-1] = 0. A negative digit is formed as the one's complement of |d_i|*a, plus a single +1 placed at column 2i.
- R2: The result is bits [2L-1:L] of S + c*2^K. Here K = L-w, S is the sum of every partial-product array bit in columns K and above (including the sign-encoding constant), and c is the estimate of R3. All arithmetic is modulo 2^(2L).
- R3: The estimate c = ceil((n_col + n_nz)/2). n_col counts the ones in column K-1, including any negative-digit +1 that lands there. n_nz counts the rows whose digit is nonzero and whose lowest column 2i lies below K.
- R4: The signed difference between the result and the rounded product round(a*b / 2^L) never exceeds 1 + floor(((L/2+1)*2^K + 2^(L-1)) / 2^L) in magnitude.
- R5: A zero multiplier operand (b_in = 0) gives a zero result.
- R6: With the output register enabled, valid_out equals valid_in delayed by exactly one clock. Reset forces valid_out and prod_out to 0.
- R7: With the output register enabled, prod_out keeps its value on every clock where valid_in is low. Operand values on such cycles have no effect.
- R8: The corner operands (most negative value, -1, 0, +1 and most positive value) in every pairing give exactly the R2 result.
- R9: Every value of w from 0 to 4 is accepted, and each such configuration obeys R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on a_in and b_in are to be multiplied |
| a_in | input | L | Multiplicand, two's complement |
| b_in | input | L | Multiplier (Booth-recoded operand), two's complement |
| valid_out | output | 1 | prod_out holds a new result |
| prod_out | output | L | Compensated fixed-width product, two's complement |

## Verification
Every result is due one clock after the rising edge that samples valid_in high. The bench drives operands on the falling edge and updates its reference model on the following rising edge. It compares all five w configurations on the next falling edge, so each comparison sees exactly one register stage. On cycles with valid_in low the model keeps the previous product, so the hold behaviour is checked on the same schedule. The error bound against the rounded product is checked on every accepted vector.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {
    DIG_Z  = 3'd0,
    DIG_P1 = 3'd1,
    DIG_P2 = 3'd2,
    DIG_M1 = 3'd3,
    DIG_M2 = 3'd4
  } booth_dig_e;

  // operand count after lv levels of 3:2 reduction
  function automatic int tree_ops(input int n0, input int lv);
    int n;
    n = n0;
    for (int k = 0; k < lv; k++)
      if (n > 2) n = 2 * (n / 3) + n % 3;
    return n;
  endfunction

  // number of 3:2 levels needed to reach two rows
  function automatic int tree_levels(input int n0);
    int n;
    int lv;
    n  = n0;
    lv = 0;
    while (n > 2) begin
      n  = 2 * (n / 3) + n % 3;
      lv = lv + 1;
    end
    return lv;
  endfunction

  // sum of -2^(l+2i) over all rows, modulo 2^64
  function automatic logic [63:0] sign_const(input int l);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < l / 2; i++)
      acc = acc - (64'd1 << (l + 2 * i));
    return acc;
  endfunction

endpackage

// File: rtl/fwb_booth_row.sv
module fwb_booth_row
  import fwb_pkg::*;
#(
  parameter int L = 16
) (
  input  logic [L-1:0] mcand,
  input  logic [2:0]   trip,
  output logic [L:0]   pat,
  output logic         neg,
  output logic         nz
);

  booth_dig_e dig;
  logic [L:0] mag;
  logic [L:0] raw;

  always_comb begin
    unique case (trip)
      3'b001, 3'b010: dig = DIG_P1;
      3'b011:         dig = DIG_P2;
      3'b100:         dig = DIG_M2;
      3'b101, 3'b110: dig = DIG_M1;
      default:        dig = DIG_Z;
    endcase
    neg = (dig == DIG_M1) || (dig == DIG_M2);
    nz  = (dig != DIG_Z);
    case (dig)
      DIG_P1, DIG_M1: mag = {mcand[L-1], mcand};
      DIG_P2, DIG_M2: mag = {mcand, 1'b0};
      default:        mag = '0;
    endcase
    raw = neg ? ~mag : mag;
    // top bit inverted: signed row value becomes raw' - 2^L (sign-encoding)
    pat = {~raw[L], raw[L-1:0]};
  end

endmodule

// File: rtl/fwb_comp.sv
module fwb_comp #(
  parameter int Q  = 8,
  parameter int CW = 4
) (
  input  logic [Q-1:0]  col_bits,
  input  logic [Q-1:0]  neg_bits,
  input  logic [Q-1:0]  nz_bits,
  output logic [CW-1:0] comp
);

  localparam int NW = $clog2(3 * Q + 2) + 1;

  logic [NW-1:0] cnt;
  logic [NW-1:0] half;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < Q; i++)
      cnt = cnt + NW'(col_bits[i]) + NW'(neg_bits[i]) + NW'(nz_bits[i]);
    half = (cnt + NW'(1)) >> 1;
    comp = half[CW-1:0];
  end

endmodule

// File: rtl/fwb_csa_tree.sv
module fwb_csa_tree
  import fwb_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic [W-1:0] ops [N],
  output logic [W-1:0] s_row,
  output logic [W-1:0] c_row
);

  localparam int LV = tree_levels(N);

  logic [W-1:0] stg [LV+1][N];

  for (genvar k = 0; k < N; k++) begin : g_in
    assign stg[0][k] = ops[k];
  end

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int NI = tree_ops(N, lv);
    localparam int G  = NI / 3;
    localparam int NO = 2 * G + NI % 3;
    for (genvar j = 0; j < G; j++) begin : g_fa
      logic [W-1:0] mj;
      assign mj = (stg[lv][3*j] & stg[lv][3*j+1]) |
                  (stg[lv][3*j] & stg[lv][3*j+2]) |
                  (stg[lv][3*j+1] & stg[lv][3*j+2]);
      assign stg[lv+1][2*j]   = stg[lv][3*j] ^ stg[lv][3*j+1] ^ stg[lv][3*j+2];
      assign stg[lv+1][2*j+1] = {mj[W-2:0], 1'b0};
    end
    for (genvar r = 0; r < NI % 3; r++) begin : g_pass
      assign stg[lv+1][2*G+r] = stg[lv][3*G+r];
    end
    for (genvar k = NO; k < N; k++) begin : g_fill
      assign stg[lv+1][k] = '0;
    end
  end

  assign s_row = stg[LV][0];
  assign c_row = stg[LV][1];

endmodule

// File: rtl/fwb_bk_add.sv
module fwb_bk_add #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);

  localparam int TOP = (N >= 4) ? (1 << ($clog2(N) - 2)) : 1;

  logic [N-1:0] g, p, gg, pp;

  always_comb begin
    g  = x & y;
    p  = x ^ y;
    gg = g;
    pp = p;
    // up-sweep
    for (int d = 1; d < N; d = d * 2)
      for (int i = 2 * d - 1; i < N; i = i + 2 * d) begin
        gg[i] = gg[i] | (pp[i] & gg[i-d]);
        pp[i] = pp[i] & pp[i-d];
      end
    // down-sweep
    for (int d = TOP; d >= 1; d = d / 2)
      for (int i = 3 * d - 1; i < N; i = i + 2 * d) begin
        gg[i] = gg[i] | (pp[i] & gg[i-d]);
        pp[i] = pp[i] & pp[i-d];
      end
    s[0] = p[0];
    for (int i = 1; i < N; i++)
      s[i] = p[i] ^ gg[i-1];
  end

endmodule

// File: rtl/fwb_mult.sv
module fwb_mult
  import fwb_pkg::*;
#(
  parameter int L       = 16,
  parameter int XCOLS   = 2,
  parameter int OUT_REG = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [L-1:0] a_in,
  input  logic [L-1:0] b_in,
  output logic         valid_out,
  output logic [L-1:0] prod_out
);

  localparam int Q  = L / 2;
  localparam int K  = L - XCOLS;        // lowest kept column
  localparam int SW = 2 * L - K;        // kept-array width
  localparam int N0 = Q + 3;            // rows + neg bits + constant + estimate
  localparam int CW = $clog2(Q + 2);
  localparam logic [63:0] CFULL = sign_const(L);

  logic [L:0]    b_ext;
  logic [L:0]    pat [Q];
  logic [Q-1:0]  neg, nz;
  logic [Q-1:0]  ecol, eneg, enz;
  logic [CW-1:0] comp;
  logic [SW-1:0] ops [N0];
  logic [SW-1:0] srow, crow, fsum;
  logic [L-1:0]  res;

  assign b_ext = {b_in, 1'b0};

  // R1: one Booth row per bit pair
  for (genvar i = 0; i < Q; i++) begin : g_row
    fwb_booth_row #(.L(L)) u_row (
      .mcand (a_in),
      .trip  (b_ext[2*i+2:2*i]),
      .pat   (pat[i]),
      .neg   (neg[i]),
      .nz    (nz[i])
    );
    // kept columns of this row
    for (genvar c = 0; c < SW; c++) begin : g_col
      localparam int REL = c + K - 2 * i;
      if (REL >= 0 && REL <= L) begin : g_on
        assign ops[i][c] = pat[i][REL];
      end else begin : g_off
        assign ops[i][c] = 1'b0;
      end
    end
    // estimation column K-1 and flags (R3)
    if (2 * i < K) begin : g_est
      assign ecol[i] = pat[i][K-1-2*i];
      assign enz[i]  = nz[i];
      if (2 * i == K - 1) begin : g_nb
        assign eneg[i] = neg[i];
      end else begin : g_nn
        assign eneg[i] = 1'b0;
      end
    end else begin : g_noest
      assign ecol[i] = 1'b0;
      assign enz[i]  = 1'b0;
      assign eneg[i] = 1'b0;
    end
  end

  // negative-digit +1 bits that fall in kept columns
  for (genvar c = 0; c < SW; c++) begin : g_negv
    localparam int COL = c + K;
    if (COL % 2 == 0 && COL / 2 < Q) begin : g_on
      assign ops[Q][c] = neg[COL/2];
    end else begin : g_off
      assign ops[Q][c] = 1'b0;
    end
  end

  assign ops[Q+1] = CFULL[2*L-1:K];
  assign ops[Q+2] = {{(SW-CW){1'b0}}, comp};

  fwb_comp #(.Q(Q), .CW(CW)) u_comp (
    .col_bits (ecol),
    .neg_bits (eneg),
    .nz_bits  (enz),
    .comp     (comp)
  );

  fwb_csa_tree #(.W(SW), .N(N0)) u_tree (
    .ops   (ops),
    .s_row (srow),
    .c_row (crow)
  );

  fwb_bk_add #(.N(SW)) u_add (
    .x (srow),
    .y (crow),
    .s (fsum)
  );

  assign res = fsum[SW-1:XCOLS];

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_out <= 1'b0;
        prod_out  <= '0;
      end else begin
        valid_out <= valid_in;
        if (valid_in) prod_out <= res;
      end
    end
  end else begin : g_comb
    assign valid_out = valid_in;
    assign prod_out  = res;
  end

endmodule

// File: rtl/fwb_mult_chk.sv
module fwb_mult_chk #(
  parameter int L       = 16,
  parameter int XCOLS   = 2,
  parameter int OUT_REG = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_in,
  input logic [L-1:0] a_in,
  input logic [L-1:0] b_in,
  input logic         valid_out,
  input logic [L-1:0] prod_out
);

  // R9
  initial param_range_chk: assert (XCOLS >= 0 && XCOLS <= 4 && L % 2 == 0 && L >= 4);

  if (OUT_REG != 0) begin : g_seq
    // R6
    reset_state_chk: assert property (@(posedge clk)
      rst |=> (!valid_out && prod_out == '0));
    // R6
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
    // R6
    idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);
    // R7
    hold_prod_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(prod_out));
    // R5
    zero_mult_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_in && b_in == '0) |=> (prod_out == '0));
  end else begin : g_cmb
    // R5
    zero_mult_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_in && b_in == '0) |-> (prod_out == '0));
    // R6
    valid_pass_chk: assert property (@(posedge clk) disable iff (rst)
      valid_out == valid_in);
  end

  logic unused_ok;
  assign unused_ok = ^a_in;

endmodule

bind fwb_mult fwb_mult_chk #(.L(L), .XCOLS(XCOLS), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .a_in      (a_in),
  .b_in      (b_in),
  .valid_out (valid_out),
  .prod_out  (prod_out)
);

// File: tb/tb_fwb_mult.sv
module tb_fwb_mult;

  localparam int L  = 16;
  localparam int Q  = L / 2;
  localparam int NW = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         vin = 1'b0;
  logic [L-1:0] a   = '0;
  logic [L-1:0] b   = '0;
  logic         vo [NW];
  logic [L-1:0] po [NW];

  always #10 clk = ~clk;

  // R9: one instance per w value
  for (genvar k = 0; k < NW; k++) begin : g_w
    logic         v_k;
    logic [L-1:0] p_k;
    fwb_mult #(.L(L), .XCOLS(k), .OUT_REG(1)) dut (
      .clk(clk), .rst(rst), .valid_in(vin), .a_in(a), .b_in(b),
      .valid_out(v_k), .prod_out(p_k)
    );
    assign vo[k] = v_k;
    assign po[k] = p_k;
  end

  int           nvec = 0;
  int           nfail = 0;
  int           ecount = 0;
  logic         ev;
  logic [L-1:0] ep [NW];
  longint       esum [NW];
  string        phase;

  // R1, R2, R3 expressed in integer arithmetic
  function automatic logic [L-1:0] model(input logic [L-1:0] x, input logic [L-1:0] y, input int w);
    longint one, xa, pr, sumlow, pat, kept, r, lowb;
    int kk, d, ng, ncol, nnz, cmp, b1, b0, bm;
    one = 1;
    kk = L - w;
    xa = longint'($signed(x));
    pr = xa * longint'($signed(y));
    sumlow = 0; ncol = 0; nnz = 0;
    for (int i = 0; i < Q; i++) begin
      b1 = int'(y[2*i+1]);
      b0 = int'(y[2*i]);
      bm = (i == 0) ? 0 : int'(y[2*i-1]);
      d  = -2 * b1 + b0 + bm;
      ng = (d < 0) ? 1 : 0;
      pat = (longint'(d) * xa - longint'(ng)) & ((one << (L + 1)) - 1);
      if (2 * i < kk) begin
        lowb = ((pat << (2 * i)) & ((one << kk) - 1)) + (longint'(ng) << (2 * i));
        sumlow = sumlow + lowb;
        if (d != 0) nnz++;
        ncol = ncol + int'((pat >> (kk - 1 - 2 * i)) & 1);
        if (2 * i == kk - 1) ncol = ncol + ng;
      end
    end
    cmp  = (ncol + nnz + 1) / 2;
    kept = pr - sumlow;
    r    = (kept + (longint'(cmp) << kk)) >>> L;
    return r[L-1:0];
  endfunction

  function automatic longint rounded(input logic [L-1:0] x, input logic [L-1:0] y);
    longint one;
    one = 1;
    return (longint'($signed(x)) * longint'($signed(y)) + (one << (L - 1))) >>> L;
  endfunction

  task automatic cmp_out(input int k);
    nvec++;
    if (vo[k] !== ev || po[k] !== ep[k]) begin
      nfail++;
      $display("FAIL %s w=%0d: valid %b prod %h, expected valid %b prod %h",
               phase, k, vo[k], po[k], ev, ep[k]);
    end
  endtask

  // called at a falling edge
  task automatic step(input logic [L-1:0] x, input logic [L-1:0] y, input logic v);
    longint err, bnd, one;
    one = 1;
    a = x; b = y; vin = v;
    @(posedge clk);
    ev = v;
    if (v) for (int k = 0; k < NW; k++) ep[k] = model(x, y, k);
    @(negedge clk);
    for (int k = 0; k < NW; k++) cmp_out(k);
    if (v) begin
      ecount++;
      for (int k = 0; k < NW; k++) begin
        // R4 error bound against the rounded product
        err = longint'($signed(po[k])) - rounded(x, y);
        bnd = ((longint'(Q + 1) << (L - k)) + (one << (L - 1))) / (one << L) + 1;
        esum[k] = esum[k] + err;
        nvec++;
        if (err > bnd || err < -bnd) begin
          nfail++;
          $display("FAIL R4 error bound w=%0d: error %0d, allowed %0d", k, err, bnd);
        end
      end
    end
  endtask

  logic [L-1:0] cv [5];
  logic [L-1:0] bp [8];

  initial begin
    ev = 1'b0;
    for (int k = 0; k < NW; k++) begin ep[k] = '0; esum[k] = 0; end
    cv[0] = {1'b1, {(L-1){1'b0}}};
    cv[1] = '1;
    cv[2] = '0;
    cv[3] = L'(1);
    cv[4] = {1'b0, {(L-1){1'b1}}};
    bp[0] = 16'h5555; bp[1] = 16'haaaa; bp[2] = 16'h3333; bp[3] = 16'hcccc;
    bp[4] = 16'h6666; bp[5] = 16'h9999; bp[6] = 16'h0f0f; bp[7] = 16'hffff;

    repeat (3) @(negedge clk);
    phase = "R6 reset state";
    for (int k = 0; k < NW; k++) cmp_out(k);
    rst = 1'b0;

    phase = "R1 digit pattern sweep";
    for (int j = 0; j < 8; j++)
      for (int n = 0; n < 6; n++) step(L'($urandom), bp[j], 1'b1);

    phase = "R8 corner operands";
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) step(cv[i], cv[j], 1'b1);

    phase = "R5 zero multiplier";
    for (int n = 0; n < 20; n++) step(L'($urandom), '0, 1'b1);

    phase = "R7 hold while idle";
    for (int n = 0; n < 20; n++) step(L'($urandom), L'($urandom), 1'b0);

    phase = "R2/R3 R6 random stream";
    for (int n = 0; n < 1500; n++)
      step(L'($urandom), L'($urandom), ($urandom % 4) != 0);

    for (int k = 0; k < NW; k++)
      $display("w=%0d mean signed error %0.4f LSB", k, real'(esum[k]) / real'(ecount));
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired before the run completed");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule